// File: doc/BRIEF.md
# Two-Level Priority Bus Arbiter

This block decides which of several masters on a shared message bus may drive the next transfer. Each master has its own request and grant wire and a flag that marks its pending request as a data message. Data messages form the high class and command messages form the low class. A low-class request is only served when no high-class request is waiting. Inside each class the winner is chosen round-robin. Each class keeps its own rotation pointer, and the search starts just after the last master served in that class.

Only one grant is active at a time. A grant stays in place until the granted master has raised the bus envelope and then dropped it. The arbiter releases the grant on that edge and arbitrates again on the next cycle. Two active-low outputs go to the masters. The first is a shared line that is low while any data-message request is pending. The second is an overload line that is low while the number of cycles spent carrying data messages in a sliding window has reached a programmable limit.

Top module: `prio_bus_arbiter`

## Requirements
- R1: At most one bit of `grantVec` is set in any cycle.
- R2: A grant goes only to a master whose `reqVec` bit was set in the cycle before the grant appears. With no request pending, `grantVec` stays all zero.
- R3: When a grant is issued while any master has both its `reqVec` and `hiVec` bits set, it goes to one of those masters. A grant already held is never taken away by a newly arriving high-class request.
- R4: Among high-class candidates, the grant goes to the first requesting index at or after the high-class pointer, counting upward and wrapping to 0. After each high-class grant the pointer becomes the winner's index plus one, modulo `NUM_REQ`.
- R5: Low-class candidates (`reqVec` set, `hiVec` clear) are chosen by the same rule using a separate low-class pointer. That pointer is unaffected by high-class grants.
- R6: A grant is issued on the clock edge after the candidate is seen in the idle state. It is held while `envelope` is high and, before `envelope` is first seen high, held indefinitely. It is removed on the edge that samples `envelope` low after it was seen high. The next grant can appear one edge later.
- R7: `hiPendN` is low exactly when some master has both its `reqVec` and `hiVec` bits set. This is combinational.
- R8: The data load is the number of the last `WINDOW` clock edges at which a high-class grant was active. `overloadN` is low exactly when that load is greater than or equal to `ovldThresh`. Cycles spent under a low-class grant do not count.
- R9: Asserting `rstN` low clears all grants and the data load at once. Both rotation pointers return to 0, so the first grant afterwards starts its search at master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqVec | input | NUM_REQ | Per-master bus request |
| hiVec | input | NUM_REQ | Per-master flag: pending request is a data message |
| envelope | input | 1 | High while the granted master is moving a message |
| ovldThresh | input | $clog2(WINDOW+1) | Data-load count at which overload is signalled |
| grantVec | output | NUM_REQ | One-hot grant, zero when idle |
| hiPendN | output | 1 | Active-low: some data-message request is pending |
| overloadN | output | 1 | Active-low: data-forwarding bandwidth exhausted |

## Verification
The main table uses four masters and mixes request patterns: all masters in the low class, a single high-class master among low-class ones, two high-class masters on either side of the pointer wrap, and a sparse low-class set. These cases separate a design that merely takes the lowest index from one that rotates. They also show whether the two class pointers stay independent. Directed cases then hold a low-class grant while a high-class request arrives, which exposes preemption. A long data transfer walks the load counter up past the threshold and back down through the window, and a low-class hold of the same length must leave the load at zero. A reset in the middle of a grant checks the clearing of grants, load and pointers.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } arbState_t;

  typedef struct packed {
    logic grantLoad;   // capture the current winner into the grant register
    logic grantDrop;   // clear the grant register
  } arbStrobe_t;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NUM_REQ = 4,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0] candVec,
  input  logic [IDX_W-1:0]   startIdx,
  output logic               anyHit,
  output logic [IDX_W-1:0]   winIdx
);

  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int off = 0; off < NUM_REQ; off++) begin
      int probe;
      probe = (int'(startIdx) + off) % NUM_REQ;
      if (!anyHit && candVec[probe]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(probe);
      end
    end
  end

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyCand,
  input  logic       envelope,
  output arbStrobe_t strb
);

  arbState_t state, stateNext;
  logic      envSeen, envSeenNext;

  always_comb begin
    stateNext      = state;
    envSeenNext    = envSeen;
    strb.grantLoad = 1'b0;
    strb.grantDrop = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (anyCand) begin
          strb.grantLoad = 1'b1;
          envSeenNext    = 1'b0;
          stateNext      = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (envelope) begin
          envSeenNext = 1'b1;
        end else if (envSeen) begin
          strb.grantDrop = 1'b1;
          envSeenNext    = 1'b0;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      envSeen <= 1'b0;
    end else begin
      state   <= stateNext;
      envSeen <= envSeenNext;
    end
  end

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int WINDOW  = 16,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int CNT_W = $clog2(WINDOW + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqVec,
  input  logic [NUM_REQ-1:0] hiVec,
  input  logic [CNT_W-1:0]   ovldThresh,
  input  arbStrobe_t         strb,
  output logic               anyCand,
  output logic [NUM_REQ-1:0] grantVec,
  output logic               hiPendN,
  output logic               overloadN
);

  localparam int LVL_HI = 1;
  localparam int LVL_LO = 0;

  logic [NUM_REQ-1:0] lvlCand [2];
  logic [IDX_W-1:0]   lvlPtr  [2];
  logic [IDX_W-1:0]   lvlWin  [2];
  logic               lvlHit  [2];

  assign lvlCand[LVL_HI] = reqVec & hiVec;
  assign lvlCand[LVL_LO] = reqVec & ~hiVec;

  genvar lvl;
  generate
    for (lvl = 0; lvl < 2; lvl++) begin : g_level
      arb_rr_pick #(.NUM_REQ(NUM_REQ)) u_pick (
        .candVec (lvlCand[lvl]),
        .startIdx(lvlPtr[lvl]),
        .anyHit  (lvlHit[lvl]),
        .winIdx  (lvlWin[lvl])
      );

      logic [IDX_W-1:0] ptrAfter;
      assign ptrAfter = (int'(lvlWin[lvl]) == NUM_REQ - 1) ? '0 : lvlWin[lvl] + IDX_W'(1);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          lvlPtr[lvl] <= '0;
        end else if (strb.grantLoad && (lvlHit[LVL_HI] == (lvl == LVL_HI))) begin
          lvlPtr[lvl] <= ptrAfter;
        end
      end
    end
  endgenerate

  logic             useHi;
  logic [IDX_W-1:0] pickIdx;

  assign useHi   = lvlHit[LVL_HI];
  assign pickIdx = useHi ? lvlWin[LVL_HI] : lvlWin[LVL_LO];
  assign anyCand = lvlHit[LVL_HI] | lvlHit[LVL_LO];
  assign hiPendN = ~lvlHit[LVL_HI];

  logic grantHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantVec <= '0;
      grantHi  <= 1'b0;
    end else if (strb.grantLoad) begin
      grantVec <= NUM_REQ'(1) << pickIdx;
      grantHi  <= useHi;
    end else if (strb.grantDrop) begin
      grantVec <= '0;
      grantHi  <= 1'b0;
    end
  end

  // Sliding window of cycles spent under a data-message grant
  logic [WINDOW-1:0] winBits;
  logic [CNT_W-1:0]  winCount;
  logic              dataBit;

  assign dataBit = (|grantVec) & grantHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winBits  <= '0;
      winCount <= '0;
    end else begin
      winBits  <= {winBits[WINDOW-2:0], dataBit};
      winCount <= winCount + CNT_W'(dataBit) - CNT_W'(winBits[WINDOW-1]);
    end
  end

  assign overloadN = ~(winCount >= ovldThresh);

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int WINDOW  = 16,
  localparam int CNT_W = $clog2(WINDOW + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqVec,
  input  logic [NUM_REQ-1:0] hiVec,
  input  logic               envelope,
  input  logic [CNT_W-1:0]   ovldThresh,
  output logic [NUM_REQ-1:0] grantVec,
  output logic               hiPendN,
  output logic               overloadN
);

  arbStrobe_t strb;
  logic       anyCand;

  arb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .anyCand (anyCand),
    .envelope(envelope),
    .strb    (strb)
  );

  arb_datapath #(.NUM_REQ(NUM_REQ), .WINDOW(WINDOW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqVec    (reqVec),
    .hiVec     (hiVec),
    .ovldThresh(ovldThresh),
    .strb      (strb),
    .anyCand   (anyCand),
    .grantVec  (grantVec),
    .hiPendN   (hiPendN),
    .overloadN (overloadN)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_REQ = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] reqVec,
  input logic [NUM_REQ-1:0] hiVec,
  input logic               envelope,
  input logic [NUM_REQ-1:0] grantVec,
  input logic               hiPendN
);

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  a_r2_grant_requested: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec == '0) |=> ((grantVec == '0) || (|(grantVec & $past(reqVec)))));

  a_r3_hi_first: assert property (@(posedge clk) disable iff (!rstN)
    ((grantVec == '0) && !hiPendN) |=> (|(grantVec & $past(hiVec))));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((|grantVec) && envelope) |=> $stable(grantVec));

endmodule

bind prio_bus_arbiter arb_checker #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqVec  (reqVec),
  .hiVec   (hiVec),
  .envelope(envelope),
  .grantVec(grantVec),
  .hiPendN (hiPendN)
);

// File: tb/tb_prio_bus_arbiter.sv
`timescale 1ns/1ps
module tb_prio_bus_arbiter;

  localparam int N     = 4;
  localparam int WIN   = 16;
  localparam int CNT_W = $clog2(WIN + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [N-1:0]     reqVec = '0;
  logic [N-1:0]     hiVec = '0;
  logic             envelope = 1'b0;
  logic [CNT_W-1:0] ovldThresh = CNT_W'(20);
  logic [N-1:0]     grantVec;
  logic             hiPendN;
  logic             overloadN;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  prio_bus_arbiter #(.NUM_REQ(N), .WINDOW(WIN)) dut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .hiVec(hiVec), .envelope(envelope),
    .ovldThresh(ovldThresh), .grantVec(grantVec), .hiPendN(hiPendN), .overloadN(overloadN)
  );

  typedef struct packed {
    logic [N-1:0] req;
    logic [N-1:0] hi;
    logic [N-1:0] expGrant;
  } vec_t;

  // Pointers start at 0 after reset; expected winners follow R4/R5 by hand.
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'b1111, 4'b0000, 4'b0001},
    '{4'b1111, 4'b0000, 4'b0010},
    '{4'b1111, 4'b0100, 4'b0100},
    '{4'b1011, 4'b1001, 4'b1000},
    '{4'b1011, 4'b1001, 4'b0001},
    '{4'b1101, 4'b0000, 4'b0100},
    '{4'b0011, 4'b0000, 4'b0001},
    '{4'b1000, 4'b0000, 4'b1000},
    '{4'b0110, 4'b0110, 4'b0010},
    '{4'b0110, 4'b0010, 4'b0010},
    '{4'b1110, 4'b0000, 4'b0010}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    @(negedge clk);
    check(grantVec, 0, "R9 grant during reset");
    rstN = 1'b1;
    cyc();
    check(grantVec, 0, "R9 grant after reset");
    check(hiPendN, 1, "R7 idle high-pending line");
    check(overloadN, 1, "R8 idle overload line");

    // R2: no request, no grant
    for (int i = 0; i < 3; i++) begin
      cyc();
      check(grantVec, 0, "R2 idle no grant");
    end

    // Table walk: each entry is a full transfer
    for (int v = 0; v < NV; v++) begin
      reqVec = VECS[v].req;
      hiVec  = VECS[v].hi;
      #1;
      check(hiPendN, ((VECS[v].req & VECS[v].hi) == 0) ? 1 : 0, "R7 pending line");
      cyc();
      check(grantVec, VECS[v].expGrant,
            ((VECS[v].req & VECS[v].hi) != 0) ? "R3,R4 high-class winner" : "R5 low-class winner");
      envelope = 1'b1;
      cyc();
      check(grantVec, VECS[v].expGrant, "R6 held in envelope");
      envelope = 1'b0;
      cyc();
      check(grantVec, 0, "R6 released after envelope");
      reqVec = '0;
      hiVec  = '0;
    end

    // No preemption; grant held before envelope is seen (R6, R3). loPtr=2, hiPtr=2.
    reqVec = 4'b0001;
    cyc();
    check(grantVec, 4'b0001, "R5 lone low request");
    reqVec = 4'b0101;
    hiVec  = 4'b0100;
    for (int i = 0; i < 3; i++) begin
      cyc();
      check(grantVec, 4'b0001, "R3 no preemption R6 hold");
    end
    envelope = 1'b1;
    cyc();
    envelope = 1'b0;
    reqVec   = 4'b0100;
    cyc();
    check(grantVec, 0, "R6 drop edge");
    cyc();
    check(grantVec, 4'b0100, "R6 re-arbitrate next cycle");
    reqVec = '0;
    hiVec  = '0;
    envelope = 1'b1;
    cyc();
    envelope = 1'b0;
    cyc();

    // Fresh reset, then a long data transfer for the load window (R8)
    rstN = 1'b0;
    cyc();
    rstN = 1'b1;
    ovldThresh = CNT_W'(4);
    reqVec = 4'b0010;
    hiVec  = 4'b0010;
    cyc();
    check(grantVec, 4'b0010, "R3 lone high request");
    envelope = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      cyc();
      if (k == 3)  check(overloadN, 1, "R8 load 3 below limit 4");
      if (k == 4)  check(overloadN, 0, "R8 load 4 reaches limit");
      if (k == 20) check(overloadN, 0, "R8 window saturated");
    end
    ovldThresh = CNT_W'(17);
    #1;
    check(overloadN, 1, "R8 limit above window");
    ovldThresh = CNT_W'(16);
    #1;
    check(overloadN, 0, "R8 limit equals full window");
    ovldThresh = CNT_W'(4);
    reqVec   = '0;
    hiVec    = '0;
    envelope = 1'b0;
    cyc();
    check(grantVec, 0, "R6 release after long hold");
    for (int j = 1; j <= 13; j++) begin
      cyc();
      if (j == 12) check(overloadN, 0, "R8 draining load 4");
      if (j == 13) check(overloadN, 1, "R8 drained below limit");
    end

    // Low-class hold must not add load (R8)
    repeat (16) cyc();
    ovldThresh = CNT_W'(1);
    #1;
    check(overloadN, 1, "R8 empty window");
    reqVec = 4'b0001;
    cyc();
    check(grantVec, 4'b0001, "R5 low grant for load test");
    envelope = 1'b1;
    repeat (20) cyc();
    check(overloadN, 1, "R8 low-class cycles not counted");
    check(grantVec, 4'b0001, "R6 long low hold");

    // Reset in mid-grant (R9)
    reqVec = '0;
    rstN = 1'b0;
    envelope = 1'b0;
    #1;
    check(grantVec, 0, "R9 async clear of grant");
    check(overloadN, 1, "R9 load cleared");
    @(negedge clk);
    rstN   = 1'b1;
    reqVec = 4'b1111;
    hiVec  = 4'b1111;
    cyc();
    check(grantVec, 4'b0001, "R9 high pointer back at 0");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule